// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Bus Ownership Handshake

This block moves a run of words from one place in memory to another without the processor. Software loads a source address, a destination address and a word count through a small register port. It then writes a go bit in the control word. The engine asks for the shared bus and waits for the arbiter's grant. While it holds the grant, it performs one read and then one write for each word. At the end it gives the bus back and raises an interrupt line.

There are two pacing choices. In continuous mode a single grant covers the whole copy, and the words follow each other back to back. In paced mode the engine asks for the bus once per word. After each word it returns the bus and stays off it for a programmed number of idle cycles, so the processor can use those slots. While a copy is running, the engine refuses every register write, and a busy flag in the control word shows this.

Register map, selected by `cfg_sel`: 0 is the source address, 1 the destination address, 2 the word count, 3 the control word. A control write uses bit 0 as go, bit 1 to clear done (write 1), bit 3 to choose paced mode and bits 15:8 for the pace value. A control read returns bit 0 busy, bit 1 done, bit 3 paced mode and bits 15:8 pace.

Top module: `dmac_mover`

## Requirements
- R1: After reset, every register reads zero and `irq` and `bus_req` are low. The source, destination and count registers read back the value last written to them.
- R2: A memory cycle (`mem_en`) happens only while `bus_gnt` is high. Once `bus_req` rises, it stays high until the grant arrives, however long the arbiter holds the grant back.
- R3: After `bus_req` falls, it stays low for as long as `bus_gnt` is still high. This is the four-phase release.
- R4: Word i is read from source+i and the same data is written to destination+i, in increasing order. No word is skipped or repeated.
- R5: In continuous mode (control bit 3 = 0) a copy raises `bus_req` exactly once.
- R6: In paced mode (control bit 3 = 1, pace P in bits 15:8) each word gets its own request. Between two requests, `bus_req` stays low for at least P+1 cycles.
- R7: When the count reaches zero, the done bit (status bit 1) is set and `irq` goes high with `bus_req` low. `irq` stays high until software writes 1 to control bit 1.
- R8: Status bit 0 reads 1 during a copy. Any register write during a copy, including a second go, has no effect.
- R9: A go with a count of zero sets done without ever raising `bus_req`.
- R10: While `mem_rdy` is low, the engine holds `mem_en`, `mem_we` and `mem_addr` steady. No word is lost while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant from the arbiter |
| mem_en | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Memory cycle completes this clock |
| irq | output | 1 | Copy finished, held until cleared |

## Verification
The bench holds the grant back for several cycles. A design that drove the memory early, or dropped its request, would show up as a bus cycle without a grant. A paced run with a nonzero pace value checks the request count and the idle gap between requests. A design that kept the bus would show one request, and one that skipped the pause would show a short gap. Random-looking memory wait states test whether a stalled read or write is lost or repeated. A second go and an address write during a busy copy test the lockout: a design that accepted them would copy twice or change the readback. A zero count tests that the engine completes without touching the bus.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int LEN_W  = 16;
    parameter int PACE_W = 8;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        REG_SRC = 2'd0,
        REG_DST = 2'd1,
        REG_LEN = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    localparam int CTL_GO      = 0;
    localparam int CTL_BUSY    = 0;
    localparam int CTL_DONE    = 1;
    localparam int CTL_THR     = 3;
    localparam int CTL_PACE_LO = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic              thr;
        logic [PACE_W-1:0] pace;
    } job_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_REL, ST_GAP
    } eng_st_e;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic busy, input logic done, input logic thr,
        input logic [PACE_W-1:0] pace);
        logic [DATA_W-1:0] s;
        s = '0;
        s[CTL_BUSY] = busy;
        s[CTL_DONE] = done;
        s[CTL_THR]  = thr;
        s[CTL_PACE_LO +: PACE_W] = pace;
        return s;
    endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy_i,
    input  logic              finish_i,
    output logic              start_o,
    output job_t              job_o,
    output logic              done_o
);
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              thr_q, done_q;
    logic [PACE_W-1:0] pace_q;
    logic              wr_ok, ctl_wr;

    // The lockout applies to every register, so a write during a copy changes nothing.
    assign wr_ok   = cfg_wr && !busy_i;
    assign ctl_wr  = wr_ok && (cfg_sel == REG_CTL);
    assign start_o = ctl_wr && cfg_wdata[CTL_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            thr_q  <= 1'b0;
            pace_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (cfg_sel)
                    REG_SRC: src_q <= cfg_wdata[ADDR_W-1:0];
                    REG_DST: dst_q <= cfg_wdata[ADDR_W-1:0];
                    REG_LEN: len_q <= cfg_wdata[LEN_W-1:0];
                    default: begin
                        thr_q  <= cfg_wdata[CTL_THR];
                        pace_q <= cfg_wdata[CTL_PACE_LO +: PACE_W];
                    end
                endcase
            end
            if (finish_i)
                done_q <= 1'b1;
            else if (ctl_wr && (cfg_wdata[CTL_DONE] || cfg_wdata[CTL_GO]))
                done_q <= 1'b0;
        end
    end

    // Pacing fields come from the go write itself, so the new copy uses them at once.
    assign job_o.src  = src_q;
    assign job_o.dst  = dst_q;
    assign job_o.len  = len_q;
    assign job_o.thr  = cfg_wdata[CTL_THR];
    assign job_o.pace = cfg_wdata[CTL_PACE_LO +: PACE_W];
    assign done_o     = done_q;

    always_comb begin
        case (cfg_sel)
            REG_SRC: cfg_rdata = {{(DATA_W-ADDR_W){1'b0}}, src_q};
            REG_DST: cfg_rdata = {{(DATA_W-ADDR_W){1'b0}}, dst_q};
            REG_LEN: cfg_rdata = {{(DATA_W-LEN_W){1'b0}}, len_q};
            default: cfg_rdata = pack_status(busy_i, done_q, thr_q, pace_q);
        endcase
    end

    assert_busy_locks_src_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && busy_i && cfg_sel == REG_SRC) |=> $stable(src_q));
    assert_done_from_finish_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(finish_i));
endmodule

// File: rtl/dmac_pacer.sv
module dmac_pacer
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [PACE_W-1:0] pace_i,
    output logic              expired_o
);
    logic [PACE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= pace_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  job_t              job_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i
);
    eng_st_e           st;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              thr_q, fin_q;
    logic [PACE_W-1:0] pace_q;
    logic [DATA_W-1:0] hold_q;
    logic              gap_load, gap_done;

    assign gap_load = (st == ST_REL) && !bus_gnt_i && (cnt_q != '0);

    dmac_pacer u_pacer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (gap_load),
        .pace_i    (pace_q),
        .expired_o (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            thr_q  <= 1'b0;
            pace_q <= '0;
            hold_q <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st)
                ST_IDLE: if (start_i) begin
                    src_q  <= job_i.src;
                    dst_q  <= job_i.dst;
                    cnt_q  <= job_i.len;
                    thr_q  <= job_i.thr;
                    pace_q <= job_i.pace;
                    if (job_i.len == '0) fin_q <= 1'b1;
                    else                 st    <= ST_REQ;
                end
                ST_REQ: if (bus_gnt_i) st <= ST_RD;
                ST_RD: if (mem_rdy_i) begin
                    hold_q <= mem_rdata_i;
                    src_q  <= src_q + 1'b1;
                    st     <= ST_WR;
                end
                ST_WR: if (mem_rdy_i) begin
                    dst_q <= dst_q + 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    st    <= (cnt_q == LEN_W'(1) || thr_q) ? ST_REL : ST_RD;
                end
                ST_REL: if (!bus_gnt_i) begin
                    if (cnt_q == '0) begin
                        fin_q <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        st <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_done) st <= ST_REQ;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (st != ST_IDLE);
    assign finish_o    = fin_q;
    assign bus_req_o   = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
    assign mem_en_o    = (st == ST_RD) || (st == ST_WR);
    assign mem_we_o    = (st == ST_WR);
    assign mem_addr_o  = (st == ST_WR) ? dst_q : src_q;
    assign mem_wdata_o = hold_q;

    assert_mem_needs_gnt_R2: assert property (@(posedge clk) disable iff (rst)
        mem_en_o |-> bus_gnt_i);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_gnt_i) |=> bus_req_o);
    assert_req_low_until_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_req_o && bus_gnt_i) |=> !bus_req_o);
    assert_zero_len_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_i && job_i.len == '0) |=> (!bus_req_o && finish_o));
    assert_wait_holds_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && !mem_rdy_i) |=> (mem_en_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/dmac_mover.sv
module dmac_mover
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              irq
);
    logic busy, finish, start, done;
    job_t job;

    dmac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy_i    (busy),
        .finish_i  (finish),
        .start_o   (start),
        .job_o     (job),
        .done_o    (done)
    );

    dmac_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .job_i       (job),
        .busy_o      (busy),
        .finish_o    (finish),
        .bus_req_o   (bus_req),
        .bus_gnt_i   (bus_gnt),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_rdy_i   (mem_rdy)
    );

    assign irq = done;

    assert_irq_without_req_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> !bus_req);
endmodule

// File: tb/test_dmac_mover.sv
module test_dmac_mover;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_req, bus_gnt, mem_en, mem_we, irq;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_rdy = 1'b1;
    logic        cpu_hold = 1'b0;
    logic        ws_mode = 1'b0;

    int errors = 0, checks = 0;
    int req_rises = 0, min_gap = 1000000, low_run = 0;
    int r2_viol = 0, r3_viol = 0, ws_cnt = 0;
    bit seen_fall = 0, prev_req = 0, r3_arm = 0, finished = 0;
    logic [31:0] mem [0:255];
    logic [47:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_mover i_dmac_mover (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req && !cpu_hold;
        if (mem_en && mem_we && mem_rdy) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: bus protocol observation and scoreboard pop on every completed write.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_en && !bus_gnt) r2_viol++;
            if (r3_arm && bus_req) r3_viol++;
            r3_arm = !bus_req && bus_gnt;
            if (bus_req && !prev_req) begin
                req_rises++;
                if (seen_fall && low_run < min_gap) min_gap = low_run;
                low_run = 0;
            end
            if (!bus_req && prev_req) seen_fall = 1;
            if (!bus_req) low_run++;
            prev_req = bus_req;
            if (mem_en && mem_we && mem_rdy) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected write", {mem_addr, mem_wdata}, 0);
                end else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R4 copied word", {mem_addr, mem_wdata}, e);
                end
            end
            ws_cnt++;
            mem_rdy = !ws_mode || (ws_cnt % 3 == 0);
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
        cfg_sel = sel;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, req, irq, 1);
    endtask

    // Driver: fills source words, pushes expected writes, programs and starts a copy.
    task automatic launch(input logic [15:0] s, input logic [15:0] d, input logic [15:0] l,
                          input bit thr, input logic [7:0] pace);
        for (int i = 0; i < l; i++) begin
            logic [31:0] v;
            v = 32'hC3A5_0000 ^ {s[7:0], 8'h00, 16'(i * 16'h0137)};
            mem[8'(s + 16'(i))] = v;
            exp_q.push_back({16'(d + 16'(i)), v});
        end
        req_rises = 0; min_gap = 1000000; seen_fall = 0; low_run = 0;
        cfg_write(2'd0, {16'h0, s});
        cfg_write(2'd1, {16'h0, d});
        cfg_write(2'd2, {16'h0, l});
        cfg_write(2'd3, {16'h0, pace, 4'h0, thr, 3'b001});
    endtask

    task automatic finish_job(input string tag);
        logic [31:0] st;
        wait_irq({tag, " R7 irq raised"});
        chk(exp_q.size() == 0, {tag, " R4 all words written"}, exp_q.size(), 0);
        cfg_read(2'd3, st);
        chk(st[1:0] == 2'b10, {tag, " R7 done set, busy clear"}, st[1:0], 2'b10);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, {tag, " R7 irq held"}, irq, 1);
        cfg_write(2'd3, 32'h2);
        chk(irq == 1'b0, {tag, " R7 irq cleared"}, irq, 0);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        cfg_read(2'd3, r); chk(r == 0, "R1 status after reset", r, 0);
        cfg_read(2'd0, r); chk(r == 0, "R1 source after reset", r, 0);
        chk(irq == 0 && bus_req == 0, "R1 irq and request low", {irq, bus_req}, 0);
        cfg_write(2'd1, 32'h0000_00E4);
        cfg_read(2'd1, r); chk(r == 32'hE4, "R1 destination readback", r, 32'hE4);

        // Continuous copy
        launch(16'h0010, 16'h0080, 16'd5, 1'b0, 8'd0);
        finish_job("cont");
        chk(req_rises == 1, "R5 single request", req_rises, 1);

        // Paced copy, pace 3
        launch(16'h0020, 16'h0090, 16'd4, 1'b1, 8'd3);
        finish_job("paced");
        chk(req_rises == 4, "R6 one request per word", req_rises, 4);
        chk(min_gap >= 4, "R6 idle gap at least pace+1", min_gap, 4);

        // Grant held back by the processor
        cpu_hold = 1'b1;
        launch(16'h0030, 16'h00A0, 16'd3, 1'b0, 8'd0);
        repeat (8) @(negedge clk);
        chk(bus_req == 1'b1, "R2 request held without grant", bus_req, 1);
        chk(mem_en == 1'b0, "R2 no cycle before grant", mem_en, 0);
        cpu_hold = 1'b0;
        finish_job("held");

        // Memory wait states
        ws_mode = 1'b1;
        launch(16'h0040, 16'h00B0, 16'd6, 1'b0, 8'd0);
        finish_job("wait R10");
        ws_mode = 1'b0;

        // Zero length
        launch(16'h0050, 16'h00C0, 16'd0, 1'b0, 8'd0);
        finish_job("zero R9");
        chk(req_rises == 0, "R9 no request for zero count", req_rises, 0);

        // Lockout while busy
        launch(16'h0060, 16'h00D0, 16'd6, 1'b1, 8'd5);
        repeat (3) @(negedge clk);
        cfg_read(2'd3, r); chk(r[0] == 1'b1, "R8 busy flag", r[0], 1);
        cfg_write(2'd0, 32'h0000_0077);
        cfg_write(2'd3, 32'h0000_0001);
        finish_job("busy");
        cfg_read(2'd0, r); chk(r == 32'h60, "R8 source write ignored", r, 32'h60);
        chk(req_rises == 6, "R8 second go ignored", req_rises, 6);

        chk(r2_viol == 0, "R2 cycles only under grant", r2_viol, 0);
        chk(r3_viol == 0, "R3 request low until grant released", r3_viol, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule